// File: doc/BRIEF.md
# Protected Watchdog Timer

This block counts prescaled clock ticks and emits a one-cycle reset pulse when the selected time-out expires while the watchdog is enabled. Software keeps the system alive by pulsing the kick input, which restarts the count. A single 8-bit control register is written through a write strobe and data bus, and it always reads back on the read port. The register holds an enable flag, a change-enable (arm) flag and a 3-bit period code. The period code selects `PRE_DIV * 2^(BASE_SHIFT + code)` clock cycles.

The register is guarded by a safety level that is captured when reset asserts. At level 0, enabling and period changes are free, but disabling is protected. At level 1, only enabling is free. At levels 2 and 3, the watchdog is locked on and reads as enabled. A protected change takes two writes. The first write sets both the arm bit and the enable bit, which opens a window lasting four cycles. The second write comes inside that window with the arm bit clear, and it carries the new enable and period values.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the read port shows period 0 and the arm bit clear. The enable bit reads 0 at levels 0 and 1 and reads 1 at levels 2 and 3. The reset output is low.
- R2: Register layout: bit 0 is enable, bit 1 is arm (change-enable), bits 4:2 are the period code, and bits 7:5 read as zero.
- R3: While enabled, the reset output pulses high for exactly one cycle `PRE_DIV * 2^(BASE_SHIFT + code)` cycles after the last restart. The count then starts again from zero.
- R4: A kick restarts the count. A kick in the same cycle as an expiry wins, so no pulse is produced and a full period follows.
- R5: A write with bit 1 and bit 0 both set opens the unlock window. The arm bit reads 1 for the four cycles after that write and then clears by itself.
- R6: At level 0, a plain write with bit 0 set enables the watchdog. Every write at level 0 loads the period code. A plain write with bit 0 clear does not disable it.
- R7: At level 1, a plain write with bit 0 set enables the watchdog. A plain write never changes the period code.
- R8: At levels 0 and 1, a write with bit 1 clear that lands inside the window loads both bit 0 and the period code, and it closes the window.
- R9: A write with bit 1 clear that arrives after the window has closed leaves the protected fields unchanged.
- R10: At levels 2 and 3, the watchdog counts from reset and enable always reads 1. The period code changes only through the window, and the enable value written inside the window is ignored.
- R11: The level is captured while reset is asserted, and later changes on the level input have no effect.
- R12: Any write that loads the period code clears the count. A disabled watchdog holds its count at zero and never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the level is captured while it is low |
| level | input | 2 | Safety level (0, 1, or 2/3 for locked) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| kick | input | 1 | Restart the time-out count |
| wdt_rst | output | 1 | One-cycle reset pulse on expiry |

## Verification
Two functions can fall in the same cycle: a kick and the expiry of the count. The bench provokes this by starting a short period and then driving the kick onto exactly the edge at which the count would run out. It judges the result by requiring the reset output to stay low after that edge and the next pulse to arrive a full period later. Window edges are also probed at their exact boundary cycles: a commit write on the fourth cycle must be applied, and one on the fifth must be ignored.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int PRE_DIV    = 4,
  parameter int BASE_SHIFT = 14,
  parameter int WIN_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] level,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       kick,
  output logic       wdt_rst
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int CW = BASE_SHIFT + 8;
  localparam int WW = $clog2(WIN_LEN + 1);

  logic [1:0]    lvl;
  logic          en;
  logic [2:0]    period;
  logic [WW-1:0] win;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;

  wire lock      = lvl[1];
  wire en_eff    = en | lock;
  wire in_win    = (win != '0);
  wire wr_open   = wr_en & wr_data[1] & wr_data[0];
  wire wr_commit = wr_en & in_win & ~wr_data[1];
  wire per_ld    = wr_commit | (wr_en & (lvl == 2'd0));
  wire restart   = kick | per_ld | ~en_eff;
  wire tick      = (pre == PW'(PRE_DIV - 1));
  wire last      = (cnt == ((CW'(1) << (BASE_SHIFT + int'(period))) - CW'(1)));
  wire expire    = en_eff & ~restart & tick & last;

  assign rd_data = {3'b000, period, in_win, en_eff};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl <= level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      period <= 3'd0;
      win    <= '0;
    end else begin
      if (per_ld) period <= wr_data[4:2];
      if (!lock) begin
        if (wr_commit)                 en <= wr_data[0];
        else if (wr_en && wr_data[0])  en <= 1'b1;
      end
      if (wr_open)        win <= WW'(WIN_LEN);
      else if (wr_commit) win <= '0;
      else if (in_win)    win <= win - WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= expire;
      if (restart || expire) begin
        pre <= '0;
        cnt <= '0;
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick) cnt <= cnt + CW'(1);
      end
    end
  end

  // R3
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R4
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(en_eff && !kick));

  // R10
  lock_reads_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> rd_data[0]);

  // R5
  win_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !wr_en) |=> (win == $past(win) - WW'(1)));

  // R9
  period_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[4:2]));

  // R8
  disable_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[0]) |-> $past(wr_en && in_win && !wr_data[1]));
endmodule

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
  localparam int PD = 2;
  localparam int BS = 2;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] level = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       kick = 0;
  logic [7:0] rd_data;
  logic       wdt_rst;

  int vec = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wdog_guard #(.PRE_DIV(PD), .BASE_SHIFT(BS), .WIN_LEN(4)) i_wdog_guard (
    .clk(clk), .rst_n(rst_n), .level(level), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .kick(kick), .wdt_rst(wdt_rst));

  function automatic logic [7:0] mk(bit e, bit a, int p);
    return {3'b000, 3'(p), a, e};
  endfunction

  function automatic int per(int p);
    return PD * (1 << (BS + p));
  endfunction

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int lv);
    @(negedge clk);
    level = 2'(lv);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int cap, output int n);
    n = 0;
    while (n < cap) begin
      @(negedge clk);
      n++;
      if (wdt_rst) break;
    end
  endtask

  task automatic open_win();
    wr(mk(1, 1, 0));
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int n;
    // ---------------- level 0 ----------------
    do_reset(0);
    chk("R1 rd", rd_data, 0);
    chk("R1 rst", wdt_rst, 0);
    wr(mk(0, 0, 5));
    chk("R6 R2 period load", rd_data, mk(0, 0, 5));
    measure(700, n);
    chk("R12 disabled no pulse", n, 700);
    for (int p = 0; p < 8; p++) begin
      wr(mk(1, 0, p));
      chk("R6 enable", rd_data, mk(1, 0, p));
      measure(5000, n);
      chk("R3 period", n, per(p));
      chk("R3 pulse width", 32'(wdt_rst), 1);
      @(negedge clk);
      chk("R3 single pulse", 32'(wdt_rst), 0);
      measure(5000, n);
      chk("R3 restart", n, per(p) - 1);
    end
    wr(mk(0, 0, 3));
    chk("R6 plain disable ignored", rd_data, mk(1, 0, 3));
    wr(mk(1, 1, 3));
    chk("R5 arm open", rd_data, mk(1, 1, 3));
    idle(3);
    wr(mk(0, 0, 3));
    chk("R8 disable lvl0 edge", rd_data, mk(0, 0, 3));
    wr(mk(1, 0, 3));
    wr(mk(1, 1, 3));
    for (int k = 0; k < 4; k++) begin
      chk("R5 arm held", rd_data[1], 1);
      @(negedge clk);
    end
    chk("R5 arm cleared", rd_data[1], 0);
    wr(mk(0, 0, 3));
    chk("R9 late disable lvl0", rd_data[0], 1);
    wr(mk(1, 0, 1));
    idle(per(1) - 1);
    kick = 1;
    @(negedge clk);
    kick = 0;
    chk("R4 kick beats expiry", 32'(wdt_rst), 0);
    measure(5000, n);
    chk("R4 full period after kick", n, per(1));
    wr(mk(1, 0, 2));
    idle(20);
    kick = 1;
    @(negedge clk);
    kick = 0;
    measure(5000, n);
    chk("R4 kick restart", n, per(2));

    // ---------------- level 1 ----------------
    do_reset(1);
    level = 0;
    chk("R1 rd lvl1", rd_data, 0);
    wr(mk(0, 0, 4));
    chk("R7 R11 plain period ignored", rd_data, 0);
    wr(mk(1, 0, 4));
    chk("R7 plain enable", rd_data, mk(1, 0, 0));
    measure(5000, n);
    chk("R7 period kept", n, per(0));
    open_win();
    wr(mk(1, 0, 6));
    chk("R8 period change lvl1", rd_data, mk(1, 0, 6));
    measure(5000, n);
    chk("R12 R8 new period", n, per(6));
    open_win();
    idle(3);
    wr(mk(0, 0, 6));
    chk("R8 disable lvl1", rd_data, mk(0, 0, 6));
    wr(mk(1, 0, 0));
    open_win();
    idle(4);
    wr(mk(0, 0, 2));
    chk("R9 late lvl1", rd_data, mk(1, 0, 6));
    for (int p = 0; p < 8; p++) begin
      open_win();
      wr(mk(1, 0, p));
      measure(5000, n);
      chk("R3 R8 sweep lvl1", n, per(p));
    end

    // ---------------- level 2 ----------------
    do_reset(2);
    chk("R1 R10 rd lvl2", rd_data, 1);
    wr(mk(0, 0, 3));
    chk("R10 plain write ignored", rd_data, 1);
    open_win();
    wr(mk(0, 0, 3));
    chk("R10 window period, en kept", rd_data, mk(1, 0, 3));
    open_win();
    idle(4);
    wr(mk(0, 0, 5));
    chk("R9 late lvl2", rd_data, mk(1, 0, 3));
    for (int p = 0; p < 8; p++) begin
      open_win();
      wr(mk(0, 0, p));
      chk("R10 en forced", rd_data[0], 1);
      measure(5000, n);
      chk("R3 R10 sweep lvl2", n, per(p));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule